// File: doc/BRIEF.md
# Programmable Event Timer with Prioritised Exception Flags

This block is one timer channel with a small register interface. Software sets a counter start value, a prescaler divide value, a compare value and a control word, and sets the run bit last. While running, the counter advances on every clock or on every prescaler tick. When it passes its all-ones value it reloads from the start value and raises an overflow flag. When it reaches the compare value it raises a compare flag.

The control word has three measurement modes. In these modes the compare flag comes from a synchronised edge on the timer input pin instead of a counter match, and the counter value at that edge is saved in a capture register. Each flag can drive its own interrupt request when enabled. An arbiter presents the single highest-priority request, with overflow ahead of compare. A flag is cleared either by writing one to its bit or by an acknowledge while its request is the one granted.

Top module: `prio_timer`

## Requirements
- R1: After reset every register reads zero, both flags are clear and every interrupt output is low.
- R2: While the run bit (control bit 0) is zero the counter (read address 4) holds the start value (address 2), and no flag is set by the counter.
- R3: With the prescale bit (control bit 1) clear the counter advances once per clock. With it set and divide value P (address 1) it advances once every P+1 clocks, the first step coming P+1 clocks after run is set.
- R4: A step taken from the all-ones counter value loads the start value and sets the overflow flag (control bit 8) on the same edge.
- R5: In modes 0 to 3 and 7 (control bits 4:2), a step that makes the counter equal the compare value (address 3) sets the compare flag (control bit 9) on the same edge.
- R6: In mode 4 a rising edge, in mode 5 a falling edge and in mode 6 either edge of the timer input sets the compare flag three clock edges after the input changes. In these modes a counter match sets no flag.
- R7: On the edge that sets the compare flag in a measurement mode, the capture register (address 5) takes the counter value held during the preceding cycle.
- R8: Writing one to control bit 8 or 9 clears that flag, and writing zero leaves it unchanged. A set and a clear on the same edge leave the flag set.
- R9: The overflow request is high exactly while the overflow flag and its enable (control bit 5) are both set. The compare request is high exactly while the compare flag and its enable (control bit 6) are both set.
- R10: The combined request is high while either request is high. The grant identifier is 1 while the overflow request is high and 0 otherwise. An acknowledge clears only the flag of the granted request.
- R11: Read data returns control at address 0, divide value at 1, start value at 2, compare value at 3, counter at 4 and capture at 5. Addresses 6 and 7 read zero, and writes to them are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address for read and write |
| bus_wdata_i | input | 24 | Write data |
| bus_rdata_o | output | 24 | Read data for the addressed register (combinational) |
| tio_i | input | 1 | Asynchronous timer input used by the measurement modes |
| irq_ovf_o | output | 1 | Overflow interrupt request |
| irq_cmp_o | output | 1 | Compare interrupt request |
| irq_req_o | output | 1 | Arbitrated request, high while any request is pending |
| irq_id_o | output | 1 | Granted request: 1 overflow, 0 compare |
| irq_ack_i | input | 1 | Acknowledge of the granted request |

## Verification
A wrong prescaler or counter state shows on the counter read port within one clock. It then moves the flag edges and the request pins by whole cycles, so a per-cycle comparison against a behavioural model catches it at once. A flag that fails to clear, clears the wrong way or loses a same-edge set shows on the request pins in the next cycle, and a wrong grant order shows on the identifier pin. A skew in the edge synchroniser moves the compare flag and the captured value by one cycle. The directed measurement checks pin both down exactly.

// File: rtl/prio_timer_pkg.sv
// Package: register addresses, control field positions and mode codes
// shared by the timer modules. Assumes a 3-bit register address.
package prio_timer_pkg;

    typedef enum logic [2:0] {
        RA_CTRL  = 3'd0,
        RA_PRE   = 3'd1,
        RA_LOAD  = 3'd2,
        RA_CMP   = 3'd3,
        RA_COUNT = 3'd4,
        RA_CAPT  = 3'd5
    } reg_addr_e;

    // Control bits kept in storage; field order fixes bit positions 6..0.
    typedef struct packed {
        logic       cmp_ie;
        logic       ovf_ie;
        logic [2:0] mode;
        logic       pre_en;
        logic       run;
    } ctrl_t;

    localparam int CTRL_BITS   = $bits(ctrl_t);
    localparam int CB_OVF_FLAG = 8;
    localparam int CB_CMP_FLAG = 9;

    localparam logic [2:0] MODE_MEAS_RISE = 3'd4;
    localparam logic [2:0] MODE_MEAS_FALL = 3'd5;
    localparam logic [2:0] MODE_MEAS_BOTH = 3'd6;

    // True for the modes whose compare event comes from the input pin.
    function automatic logic is_measure(input logic [2:0] mode);
        return (mode == MODE_MEAS_RISE) || (mode == MODE_MEAS_FALL) ||
               (mode == MODE_MEAS_BOTH);
    endfunction

endpackage

// File: rtl/prio_timer_prescale.sv
// Prescaler: a down-counter reloaded from the divide value that yields a
// tick each time it sits at zero. When bypassed, or while the timer is
// stopped, it is held at the divide value. With bypass the tick follows run.
module prio_timer_prescale #(
    parameter int PRE_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             pre_en_i,
    input  logic [PRE_W-1:0] div_i,
    output logic             tick_o
);

    logic [PRE_W-1:0] div_q;

    // Purpose: count down, reload at zero, hold while idle or bypassed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (!run_i || !pre_en_i) begin
            div_q <= div_i;
        end else if (div_q == '0) begin
            div_q <= div_i;
        end else begin
            div_q <= div_q - 1'b1;
        end
    end

    // Purpose: tick every clock when bypassed, else on reaching zero.
    always_comb begin
        tick_o = run_i && (!pre_en_i || (div_q == '0));
    end

    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && pre_en_i && tick_o && div_i != '0) |=> (!tick_o || !pre_en_i)); // R3

endmodule

// File: rtl/prio_timer_count.sv
// Main counter: steps up on each tick, wraps from all ones to the start
// value and reports overflow and match events for the flag stage.
// While stopped it continuously loads the start value.
module prio_timer_count #(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             tick_i,
    input  logic             measure_i,
    input  logic [CNT_W-1:0] load_i,
    input  logic [CNT_W-1:0] cmp_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             ovf_evt_o,
    output logic             match_evt_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nxt;
    logic             wrap;

    // Purpose: next counter value for a tick, wrapping to the start value.
    always_comb begin
        wrap    = (cnt_q == CNT_MAX);
        cnt_nxt = wrap ? load_i : cnt_q + 1'b1;
    end

    // Purpose: counter register, loaded while stopped, stepped on tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run_i) begin
            cnt_q <= load_i;
        end else if (tick_i) begin
            cnt_q <= cnt_nxt;
        end
    end

    // Purpose: events raised on the same edge as the counter step.
    always_comb begin
        ovf_evt_o   = run_i && tick_i && wrap;
        match_evt_o = run_i && tick_i && !measure_i && (cnt_nxt == cmp_i);
        cnt_o       = cnt_q;
    end

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt_o == $past(load_i))); // R2
    AST_WRAP_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && tick_i && cnt_q == CNT_MAX) |=> (cnt_o == $past(load_i))); // R4

endmodule

// File: rtl/prio_timer_capture.sv
// Input stage for the measurement modes: synchronises the pin through
// SYNC_N flip-flops, picks the edge the mode asks for and saves the
// counter value on that edge. The pin may change at any time.
module prio_timer_capture #(
    parameter int CNT_W  = 24,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tio_i,
    input  logic             run_i,
    input  logic [2:0]       mode_i,
    input  logic [CNT_W-1:0] cnt_i,
    output logic             edge_o,
    output logic [CNT_W-1:0] cap_o
);

    import prio_timer_pkg::*;

    logic [SYNC_N:0]  sync_q;
    logic [CNT_W-1:0] cap_q;
    logic             lvl_now;
    logic             lvl_prev;
    logic             rise;
    logic             fall;

    // Purpose: synchroniser chain plus one stage of history for edges.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_N-1:0], tio_i};
        end
    end

    // Purpose: select the edge type required by the active mode.
    always_comb begin
        lvl_now  = sync_q[SYNC_N-1];
        lvl_prev = sync_q[SYNC_N];
        rise     = lvl_now && !lvl_prev;
        fall     = !lvl_now && lvl_prev;
        edge_o   = 1'b0;
        if (run_i) begin
            case (mode_i)
                MODE_MEAS_RISE: edge_o = rise;
                MODE_MEAS_FALL: edge_o = fall;
                MODE_MEAS_BOTH: edge_o = rise || fall;
                default:        edge_o = 1'b0;
            endcase
        end
    end

    // Purpose: capture register, written on each selected edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q <= '0;
        end else if (edge_o) begin
            cap_q <= cnt_i;
        end
    end

    assign cap_o = cap_q;

    AST_CAPTURE_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        edge_o |=> (cap_o == $past(cnt_i))); // R7

endmodule

// File: rtl/prio_timer_flags.sv
// Exception flags and fixed-priority arbiter. Each flag sets on its event
// and clears on write-one or on an acknowledge of its granted request.
// A set wins over a clear on the same edge. Overflow outranks compare.
module prio_timer_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_set_i,
    input  logic cmp_set_i,
    input  logic ovf_w1c_i,
    input  logic cmp_w1c_i,
    input  logic ovf_ie_i,
    input  logic cmp_ie_i,
    input  logic ack_i,
    output logic ovf_flag_o,
    output logic cmp_flag_o,
    output logic irq_ovf_o,
    output logic irq_cmp_o,
    output logic irq_req_o,
    output logic irq_id_o
);

    logic ovf_q;
    logic cmp_q;
    logic ovf_ack;
    logic cmp_ack;

    // Purpose: gate flags into requests and route the acknowledge.
    always_comb begin
        irq_ovf_o = ovf_q && ovf_ie_i;
        irq_cmp_o = cmp_q && cmp_ie_i;
        irq_req_o = irq_ovf_o || irq_cmp_o;
        irq_id_o  = irq_ovf_o;
        ovf_ack   = ack_i && irq_ovf_o;
        cmp_ack   = ack_i && irq_cmp_o && !irq_ovf_o;
    end

    // Purpose: overflow flag, set has priority over either clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (ovf_set_i) begin
            ovf_q <= 1'b1;
        end else if (ovf_w1c_i || ovf_ack) begin
            ovf_q <= 1'b0;
        end
    end

    // Purpose: compare flag, set has priority over either clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmp_q <= 1'b0;
        end else if (cmp_set_i) begin
            cmp_q <= 1'b1;
        end else if (cmp_w1c_i || cmp_ack) begin
            cmp_q <= 1'b0;
        end
    end

    assign ovf_flag_o = ovf_q;
    assign cmp_flag_o = cmp_q;

    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_set_i && ovf_w1c_i) |=> ovf_flag_o); // R8
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_set_i && !ovf_w1c_i && !ack_i) |=> $stable(ovf_flag_o)); // R8
    AST_ACK_SPARES_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_ovf_o && !cmp_set_i && !cmp_w1c_i) |=> (cmp_flag_o == $past(cmp_flag_o))); // R10
    AST_ACK_CLEARS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && irq_ovf_o && !ovf_set_i) |=> !ovf_flag_o); // R10

endmodule

// File: rtl/prio_timer.sv
// Timer channel top: register file and read mux around the prescaler,
// counter, input capture and flag/arbiter stages. Assumes software writes
// configuration before setting run. Reads are combinational on the address.
module prio_timer #(
    parameter int CNT_W  = 24,
    parameter int PRE_W  = 16,
    parameter int SYNC_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr_i,
    input  logic [2:0]       bus_addr_i,
    input  logic [CNT_W-1:0] bus_wdata_i,
    output logic [CNT_W-1:0] bus_rdata_o,
    input  logic             tio_i,
    output logic             irq_ovf_o,
    output logic             irq_cmp_o,
    output logic             irq_req_o,
    output logic             irq_id_o,
    input  logic             irq_ack_i
);

    import prio_timer_pkg::*;

    localparam int DATA_W = CNT_W;

    ctrl_t            ctrl_q;
    logic [PRE_W-1:0] div_q;
    logic [CNT_W-1:0] load_q;
    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cap;
    logic [DATA_W-1:0] ctrl_word;
    logic             tick;
    logic             measure;
    logic             ovf_evt;
    logic             match_evt;
    logic             edge_evt;
    logic             ctrl_wr;
    logic             ovf_flag;
    logic             cmp_flag;

    // Purpose: decode control writes and the measurement-mode flag.
    always_comb begin
        ctrl_wr = bus_wr_i && (bus_addr_i == RA_CTRL);
        measure = is_measure(ctrl_q.mode);
    end

    // Purpose: configuration registers written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            div_q  <= '0;
            load_q <= '0;
            cmp_q  <= '0;
        end else if (bus_wr_i) begin
            case (bus_addr_i)
                RA_CTRL: ctrl_q <= ctrl_t'(bus_wdata_i[CTRL_BITS-1:0]);
                RA_PRE:  div_q  <= bus_wdata_i[PRE_W-1:0];
                RA_LOAD: load_q <= bus_wdata_i;
                RA_CMP:  cmp_q  <= bus_wdata_i;
                default: ;
            endcase
        end
    end

    prio_timer_prescale #(.PRE_W(PRE_W)) i_prescale (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_i    (ctrl_q.run),
        .pre_en_i (ctrl_q.pre_en),
        .div_i    (div_q),
        .tick_o   (tick)
    );

    prio_timer_count #(.CNT_W(CNT_W)) i_count (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (ctrl_q.run),
        .tick_i      (tick),
        .measure_i   (measure),
        .load_i      (load_q),
        .cmp_i       (cmp_q),
        .cnt_o       (cnt),
        .ovf_evt_o   (ovf_evt),
        .match_evt_o (match_evt)
    );

    prio_timer_capture #(.CNT_W(CNT_W), .SYNC_N(SYNC_N)) i_capture (
        .clk    (clk),
        .rst_n  (rst_n),
        .tio_i  (tio_i),
        .run_i  (ctrl_q.run),
        .mode_i (ctrl_q.mode),
        .cnt_i  (cnt),
        .edge_o (edge_evt),
        .cap_o  (cap)
    );

    prio_timer_flags i_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .ovf_set_i  (ovf_evt),
        .cmp_set_i  (match_evt || edge_evt),
        .ovf_w1c_i  (ctrl_wr && bus_wdata_i[CB_OVF_FLAG]),
        .cmp_w1c_i  (ctrl_wr && bus_wdata_i[CB_CMP_FLAG]),
        .ovf_ie_i   (ctrl_q.ovf_ie),
        .cmp_ie_i   (ctrl_q.cmp_ie),
        .ack_i      (irq_ack_i),
        .ovf_flag_o (ovf_flag),
        .cmp_flag_o (cmp_flag),
        .irq_ovf_o  (irq_ovf_o),
        .irq_cmp_o  (irq_cmp_o),
        .irq_req_o  (irq_req_o),
        .irq_id_o   (irq_id_o)
    );

    // Purpose: assemble the readable control/status word.
    always_comb begin
        ctrl_word                  = '0;
        ctrl_word[CTRL_BITS-1:0]   = ctrl_q;
        ctrl_word[CB_OVF_FLAG]     = ovf_flag;
        ctrl_word[CB_CMP_FLAG]     = cmp_flag;
    end

    // Purpose: read multiplexer, zero for unmapped addresses.
    always_comb begin
        case (bus_addr_i)
            RA_CTRL:  bus_rdata_o = ctrl_word;
            RA_PRE:   bus_rdata_o = DATA_W'(div_q);
            RA_LOAD:  bus_rdata_o = load_q;
            RA_CMP:   bus_rdata_o = cmp_q;
            RA_COUNT: bus_rdata_o = cnt;
            RA_CAPT:  bus_rdata_o = cap;
            default:  bus_rdata_o = '0;
        endcase
    end

    AST_REQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.ovf_ie && !ctrl_q.cmp_ie) |-> !irq_req_o); // R9
    AST_OVF_GRANT_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ovf_o && irq_cmp_o) |-> irq_id_o); // R10
    AST_STOPPED_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.run && !ovf_flag) |=> !ovf_flag); // R2

endmodule

// File: tb/test_prio_timer.sv
module test_prio_timer;

    localparam int CLK_PERIOD = 10;
    localparam int CW = 24;
    localparam int PW = 16;
    localparam logic [CW-1:0] MAXV = '1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_wr = 1'b0;
    logic [2:0]    bus_addr = 3'd0;
    logic [CW-1:0] bus_wdata = '0;
    logic [CW-1:0] bus_rdata;
    logic          tio = 1'b0;
    logic          irq_ovf, irq_cmp, irq_req, irq_id;
    logic          irq_ack = 1'b0;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    prio_timer i_prio_timer (
        .clk(clk), .rst_n(rst_n), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata), .tio_i(tio),
        .irq_ovf_o(irq_ovf), .irq_cmp_o(irq_cmp), .irq_req_o(irq_req),
        .irq_id_o(irq_id), .irq_ack_i(irq_ack)
    );

    // ---------------- behavioural reference model ----------------
    bit            m_run, m_pre_en, m_oie, m_cie, m_of, m_cf;
    logic [2:0]    m_mode;
    logic [PW-1:0] m_div, m_pcnt;
    logic [CW-1:0] m_load, m_cmp, m_cnt, m_cap;
    bit            tio_hist[$];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_pre_en = 0; m_oie = 0; m_cie = 0; m_of = 0; m_cf = 0;
            m_mode = 0; m_div = 0; m_pcnt = 0; m_load = 0; m_cmp = 0;
            m_cnt = 0; m_cap = 0;
            tio_hist = '{1'b0, 1'b0, 1'b0};
        end else begin
            bit tk, oe, me, ee, meas, io, ic, wo, wc;
            logic [CW-1:0] nx;
            meas = (m_mode == 3'd4) || (m_mode == 3'd5) || (m_mode == 3'd6);
            tk = m_run && (!m_pre_en || m_pcnt == 0);
            oe = tk && (m_cnt == MAXV);
            nx = oe ? m_load : m_cnt + 1;
            me = tk && !meas && (nx == m_cmp);
            ee = 0;
            if (m_run) begin
                if (m_mode == 3'd4) ee = tio_hist[1] && !tio_hist[2];
                if (m_mode == 3'd5) ee = !tio_hist[1] && tio_hist[2];
                if (m_mode == 3'd6) ee = tio_hist[1] != tio_hist[2];
            end
            io = m_of && m_oie;
            ic = m_cf && m_cie;
            wo = bus_wr && bus_addr == 3'd0 && bus_wdata[8];
            wc = bus_wr && bus_addr == 3'd0 && bus_wdata[9];
            if (ee) m_cap = m_cnt;
            if (oe) m_of = 1;
            else if (wo || (irq_ack && io)) m_of = 0;
            if (me || ee) m_cf = 1;
            else if (wc || (irq_ack && ic && !io)) m_cf = 0;
            if (!m_run || !m_pre_en) m_pcnt = m_div;
            else if (m_pcnt == 0) m_pcnt = m_div;
            else m_pcnt = m_pcnt - 1;
            if (!m_run) m_cnt = m_load;
            else if (tk) m_cnt = nx;
            tio_hist.push_front(tio);
            void'(tio_hist.pop_back());
            if (bus_wr) begin
                case (bus_addr)
                    3'd0: {m_cie, m_oie, m_mode, m_pre_en, m_run} = bus_wdata[6:0];
                    3'd1: m_div = bus_wdata[PW-1:0];
                    3'd2: m_load = bus_wdata;
                    3'd3: m_cmp = bus_wdata;
                    default: ;
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison of every output against the model (R1..R11).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            logic [CW-1:0] e;
            string t;
            bit eo, ec;
            eo = m_of && m_oie;
            ec = m_cf && m_cie;
            chk(irq_ovf == eo, "R9 irq_ovf", irq_ovf, eo);
            chk(irq_cmp == ec, "R9 irq_cmp", irq_cmp, ec);
            chk(irq_req == (eo || ec), "R10 irq_req", irq_req, eo || ec);
            chk(irq_id == eo, "R10 irq_id", irq_id, eo);
            case (bus_addr)
                3'd0: begin e = CW'({m_cf, m_of, 1'b0, m_cie, m_oie, m_mode, m_pre_en, m_run}); t = "R8 ctrl"; end
                3'd1: begin e = CW'(m_div); t = "R11 div"; end
                3'd2: begin e = m_load; t = "R11 load"; end
                3'd3: begin e = m_cmp; t = "R11 cmp"; end
                3'd4: begin e = m_cnt; t = "R3 count"; end
                3'd5: begin e = m_cap; t = "R7 capture"; end
                default: begin e = '0; t = "R11 unmapped"; end
            endcase
            chk(bus_rdata == e, t, bus_rdata, e);
        end
    end

    // ---------------- stimulus helpers (start/end at posedge+1) ----------------
    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        step(1);
        bus_wr = 0;
    endtask

    task automatic expect_rd(input logic [2:0] a, input logic [CW-1:0] exp, input string tag);
        bus_addr = a;
        @(negedge clk);
        chk(bus_rdata == exp, tag, bus_rdata, exp);
        step(1);
    endtask

    task automatic expect_pin(input logic act, input logic exp, input string tag);
        chk(act == exp, tag, act, exp);
    endtask

    task automatic ack_pulse;
        irq_ack = 1;
        step(1);
        irq_ack = 0;
    endtask

    task automatic finish_up;
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired, actual=running expected=finished");
        finish_up();
    end

    initial begin
        logic [CW-1:0] c0;
        int guard;
        step(4);
        rst_n = 1;
        step(1);
        // R1: reset state
        expect_rd(3'd0, 24'h0, "R1 ctrl after reset");
        expect_rd(3'd4, 24'h0, "R1 count after reset");
        expect_pin(irq_req, 1'b0, "R1 irq_req after reset");

        // R2: stopped counter follows the start value
        wr(3'd2, 24'd100);
        wr(3'd3, 24'd101);
        step(5);
        expect_rd(3'd4, 24'd100, "R2 count holds start value");
        expect_rd(3'd0, 24'h0, "R2 no flag while stopped");
        // R11: unmapped address ignores writes and reads zero
        wr(3'd6, 24'h123456);
        expect_rd(3'd6, 24'h0, "R11 unmapped reads zero");
        expect_rd(3'd2, 24'd100, "R11 start value readback");

        // R5/R9: compare match without prescaler
        wr(3'd2, 24'd0);
        wr(3'd3, 24'd10);
        wr(3'd0, 24'h041);
        step(15);
        expect_pin(irq_cmp, 1'b1, "R9 compare request up");
        expect_rd(3'd0, 24'h241, "R5 compare flag set");
        wr(3'd0, 24'h041);
        expect_rd(3'd0, 24'h241, "R8 write zero keeps flag");
        wr(3'd0, 24'h241);
        expect_rd(3'd0, 24'h041, "R8 write one clears flag");
        expect_pin(irq_cmp, 1'b0, "R9 compare request down");

        // R3: prescaler divide by 4, then bypass
        wr(3'd0, 24'h000);
        wr(3'd1, 24'd3);
        wr(3'd3, 24'd1000);
        wr(3'd0, 24'h003);
        step(8);
        expect_rd(3'd4, 24'd2, "R3 prescaled step count");
        wr(3'd0, 24'h001);
        step(4);
        expect_rd(3'd4, 24'd6, "R3 unprescaled step count");

        // R4/R10: overflow and compare both pending, priority and ack
        wr(3'd0, 24'h000);
        wr(3'd2, 24'hFFFFF0);
        wr(3'd3, 24'hFFFFF8);
        wr(3'd0, 24'h061);
        guard = 0;
        while (!irq_ovf && guard < 40) begin step(1); guard++; end
        expect_pin(irq_ovf, 1'b1, "R4 overflow request seen");
        expect_pin(irq_id, 1'b1, "R10 overflow granted first");
        expect_pin(irq_cmp, 1'b1, "R10 compare still pending");
        ack_pulse();
        expect_pin(irq_ovf, 1'b0, "R10 ack clears overflow");
        expect_pin(irq_cmp, 1'b1, "R10 ack spares compare");
        expect_pin(irq_id, 1'b0, "R10 grant moves to compare");
        ack_pulse();
        expect_pin(irq_req, 1'b0, "R10 second ack clears compare");
        wr(3'd0, 24'h300);

        // R6/R7: measurement, rising edge
        wr(3'd2, 24'd0);
        wr(3'd3, 24'd2);
        wr(3'd0, 24'h051);
        step(10);
        expect_rd(3'd0, 24'h051, "R6 no match flag in measure mode");
        tio = 1;
        bus_addr = 3'd4;
        @(negedge clk);
        c0 = bus_rdata;
        step(3);
        expect_rd(3'd5, c0 + 24'd2, "R7 captured count");
        expect_rd(3'd0, 24'h251, "R6 rising edge sets flag");
        wr(3'd0, 24'h251);
        tio = 0;
        step(6);
        expect_rd(3'd0, 24'h051, "R6 falling ignored in rising mode");
        // falling mode
        wr(3'd0, 24'h055);
        tio = 1;
        step(6);
        expect_rd(3'd0, 24'h055, "R6 rising ignored in falling mode");
        tio = 0;
        step(4);
        expect_rd(3'd0, 24'h255, "R6 falling edge sets flag");
        // both edges mode
        wr(3'd0, 24'h259);
        tio = 1;
        step(4);
        expect_rd(3'd0, 24'h259, "R6 either edge sets flag");

        // Mixed stimulus, checked every cycle against the model (R8 set-wins etc.)
        wr(3'd0, 24'h300);
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = $urandom_range(0, 15);
            irq_ack = ($urandom_range(0, 7) == 0);
            if ($urandom_range(0, 9) == 0) tio = ~tio;
            bus_addr = 3'($urandom_range(0, 7));
            bus_wr = (r < 4);
            case (bus_addr)
                3'd1: bus_wdata = CW'($urandom_range(0, 3));
                3'd2, 3'd3: bus_wdata = 24'hFFFF00 | CW'($urandom_range(0, 255));
                default: bus_wdata = CW'($urandom_range(0, 1023)) | 24'h001;
            endcase
            step(1);
        end
        bus_wr = 0;
        irq_ack = 0;
        step(2);
        finish_up();
    end

endmodule